// File: doc/BRIEF.md
# Bus Inactivity Power-Down Controller

This block sits between a microcontroller's multiplexed address/data bus and the on-chip memories and programmable logic arrays that decode it. It saves power in two ways. First, it watches the address strobe. When the strobe has not changed for a programmable number of clock cycles, and power-down is enabled, the block enters a powered-down state. In that state it freezes every bus signal it forwards and deselects the memories. The first strobe transition afterwards wakes the block.

Second, the microcontroller can write a few mode bits at run time. Two of these bits freeze signal groups that the logic arrays do not need: the low address byte, and the control group. The control group is the three control lines, the address strobe and the high-byte write enable. A third bit turns turbo mode off. A separate active-low chip-select input deselects the memories without gating any bus signal.

The block holds frozen signals at their last passed value instead of forcing them to zero, so downstream inputs stop toggling. The bus itself is a raw, cycle-timed interface with no handshake. Every pin is plain control or status, and no back-pressure applies. The configuration port is a single-cycle write strobe. It is always accepted.

Top module: `bus_idle_pwrdn`

## Requirements
- R1: After reset, `pwr_down_o` is 0 and `turbo_on_o` is 1. Power-down is disabled, both blocking bits are clear, all bus outputs follow their inputs, and the idle limit is 255.
- R2: A transition of `bus_ale_i` in either direction, as sampled on consecutive clock edges, restarts the idle count from zero.
- R3: Let the idle limit be T, written at address 2. With power-down enabled, `pwr_down_o` rises at the clock edge that ends the (T+1)th consecutive cycle without a strobe transition. The count saturates, so T = 255 is reachable.
- R4: Power-down enable is address 0, bit 1. While it is 0, `pwr_down_o` stays 0. Clearing it while powered down drops `pwr_down_o` one cycle after the register write. Setting it after a long idle period causes entry at the next clock edge.
- R5: While `pwr_down_o` is 1, `mem_ad_o`, `pld_ad_o`, `pld_ctl_o`, `pld_ale_o` and `pld_wrh_o` hold the values they had in the last cycle before entry.
- R6: While `pwr_down_o` is 1, `mem_sel_o` is 0 whatever `mem_sel_i` is.
- R7: The first strobe transition while powered down clears `pwr_down_o` at that clock edge and restarts the idle count. From the next cycle on, the outputs follow their inputs again.
- R8: When `cs_in_n` is 1, `mem_sel_o` is 0, while all bus outputs still follow their inputs.
- R9: Address 1, bit 0 freezes `pld_ad_o[7:0]` only. `pld_ad_o[15:8]` and `mem_ad_o` keep following the bus.
- R10: Address 1, bit 1 freezes `pld_ctl_o`, `pld_ale_o` and `pld_wrh_o`. The idle monitor still sees every strobe transition.
- R11: Address 0, bit 0 set to 1 turns turbo off (`turbo_on_o` = 0). Clearing it turns turbo back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ad_i | input | 16 | Multiplexed address/data from the microcontroller |
| bus_ctl_i | input | 3 | Control lines from the microcontroller |
| bus_ale_i | input | 1 | Address strobe |
| bus_wrh_i | input | 1 | High-byte write enable |
| cs_in_n | input | 1 | External chip select, active low |
| mem_sel_i | input | 1 | Memory select from the address decode |
| cfg_we_i | input | 1 | Mode register write strobe |
| cfg_addr_i | input | 2 | Mode register address |
| cfg_wdata_i | input | 8 | Mode register write data |
| mem_ad_o | output | 16 | Address/data to the memories |
| pld_ad_o | output | 16 | Address/data to the logic arrays |
| pld_ctl_o | output | 3 | Control lines to the logic arrays |
| pld_ale_o | output | 1 | Address strobe to the logic arrays |
| pld_wrh_o | output | 1 | High-byte write enable to the logic arrays |
| mem_sel_o | output | 1 | Memory select after deselect gating |
| pwr_down_o | output | 1 | Powered-down status |
| turbo_on_o | output | 1 | Turbo mode enable |

## Verification
A wrong idle count shows at `pwr_down_o` only as a shift of one or more cycles in the entry edge. The bench therefore sweeps a range of idle limits, including the saturating one, and checks `pwr_down_o` cycle by cycle after a strobe transition. A hold register that captured the wrong cycle's value, or that updates while frozen, shows on the next bus change while the group is blocked. A failure to clear the count on wake-up appears as a re-entry at the wrong cycle within T+2 clocks.

// File: rtl/bipd_pkg.sv
package bipd_pkg;
  localparam int IDLE_W = 8;
  localparam int CFG_AW = 2;

  typedef enum logic [CFG_AW-1:0] {
    RA_MODE  = 2'd0,
    RA_BLOCK = 2'd1,
    RA_IDLE  = 2'd2
  } cfg_addr_e;

  typedef struct packed {
    logic              turbo_off;
    logic              pd_en;
    logic              blk_low;
    logic              blk_ctl;
    logic [IDLE_W-1:0] idle_lim;
  } cfg_t;
endpackage

// File: rtl/bipd_cfg_regs.sv
module bipd_cfg_regs
  import bipd_pkg::*;
#(
  parameter logic [IDLE_W-1:0] IDLE_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [IDLE_W-1:0] wdata_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.turbo_off <= 1'b0;
      cfg_q.pd_en     <= 1'b0;
      cfg_q.blk_low   <= 1'b0;
      cfg_q.blk_ctl   <= 1'b0;
      cfg_q.idle_lim  <= IDLE_RST;
    end else if (we_i) begin
      case (addr_i)
        RA_MODE: begin
          cfg_q.turbo_off <= wdata_i[0];
          cfg_q.pd_en     <= wdata_i[1];
        end
        RA_BLOCK: begin
          cfg_q.blk_low <= wdata_i[0];
          cfg_q.blk_ctl <= wdata_i[1];
        end
        RA_IDLE: cfg_q.idle_lim <= wdata_i;
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;

  AST_RESET_TURBO_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !cfg_q.turbo_off); // R1
endmodule

// File: rtl/bipd_idle_timer.sv
module bipd_idle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_i,
  input  logic         pd_en_i,
  input  logic [W-1:0] limit_i,
  output logic         pd_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic         strobe_q;
  logic         act;
  logic [W-1:0] cnt_q;
  logic         pd_q;

  assign act = strobe_i ^ strobe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (act)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pd_q <= 1'b0;
    else if (!pd_en_i || act)            pd_q <= 1'b0;
    else if (!pd_q && cnt_q >= limit_i)  pd_q <= 1'b1;
  end

  assign pd_o = pd_q;

  AST_WAKE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q && act) |=> !pd_q); // R7
  AST_NO_PD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_en_i |=> !pd_q); // R4
  AST_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_q) |-> $past(!act)); // R3
  AST_COUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/bipd_hold_gate.sv
module bipd_hold_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         blk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (!blk_i) hold_q <= d_i;
  end

  assign q_o = blk_i ? hold_q : d_i;

  AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_i && $past(blk_i)) |-> (q_o == $past(q_o))); // R5
endmodule

// File: rtl/bus_idle_pwrdn.sv
module bus_idle_pwrdn
  import bipd_pkg::*;
#(
  parameter int AD_W  = 16,
  parameter int LOW_W = 8,
  parameter int CTL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AD_W-1:0]   bus_ad_i,
  input  logic [CTL_W-1:0]  bus_ctl_i,
  input  logic              bus_ale_i,
  input  logic              bus_wrh_i,
  input  logic              cs_in_n,
  input  logic              mem_sel_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [IDLE_W-1:0] cfg_wdata_i,
  output logic [AD_W-1:0]   mem_ad_o,
  output logic [AD_W-1:0]   pld_ad_o,
  output logic [CTL_W-1:0]  pld_ctl_o,
  output logic              pld_ale_o,
  output logic              pld_wrh_o,
  output logic              mem_sel_o,
  output logic              pwr_down_o,
  output logic              turbo_on_o
);
  localparam int HIGH_W = AD_W - LOW_W;
  localparam int GRP_W  = CTL_W + 2;

  cfg_t             cfg;
  logic             pd;
  logic [GRP_W-1:0] grp_in;
  logic [GRP_W-1:0] grp_out;

  bipd_cfg_regs #(.IDLE_RST('1)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .cfg_o(cfg)
  );

  bipd_idle_timer #(.W(IDLE_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .strobe_i(bus_ale_i), .pd_en_i(cfg.pd_en),
    .limit_i(cfg.idle_lim), .pd_o(pd)
  );

  bipd_hold_gate #(.W(AD_W)) u_mem_ad (
    .clk(clk), .rst_n(rst_n), .blk_i(pd), .d_i(bus_ad_i), .q_o(mem_ad_o)
  );

  bipd_hold_gate #(.W(LOW_W)) u_pld_lo (
    .clk(clk), .rst_n(rst_n), .blk_i(pd | cfg.blk_low),
    .d_i(bus_ad_i[LOW_W-1:0]), .q_o(pld_ad_o[LOW_W-1:0])
  );

  generate
    if (HIGH_W > 0) begin : g_high
      bipd_hold_gate #(.W(HIGH_W)) u_pld_hi (
        .clk(clk), .rst_n(rst_n), .blk_i(pd),
        .d_i(bus_ad_i[AD_W-1:LOW_W]), .q_o(pld_ad_o[AD_W-1:LOW_W])
      );
    end
  endgenerate

  assign grp_in = {bus_wrh_i, bus_ale_i, bus_ctl_i};

  bipd_hold_gate #(.W(GRP_W)) u_pld_ctl (
    .clk(clk), .rst_n(rst_n), .blk_i(pd | cfg.blk_ctl), .d_i(grp_in), .q_o(grp_out)
  );

  assign pld_ctl_o  = grp_out[CTL_W-1:0];
  assign pld_ale_o  = grp_out[CTL_W];
  assign pld_wrh_o  = grp_out[CTL_W+1];
  assign mem_sel_o  = mem_sel_i & ~cs_in_n & ~pd;
  assign pwr_down_o = pd;
  assign turbo_on_o = ~cfg.turbo_off;

  AST_PD_MEM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down_o && $past(pwr_down_o)) |-> $stable(mem_ad_o)); // R5
  AST_WAKE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down_o) |-> (mem_ad_o == bus_ad_i)); // R7
  AST_PD_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_down_o) |-> !mem_sel_o); // R6
endmodule

// File: tb/test_bus_idle_pwrdn.sv
module test_bus_idle_pwrdn;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_ad_i = '0;
  logic [2:0]  bus_ctl_i = '0;
  logic        bus_ale_i = 1'b0;
  logic        bus_wrh_i = 1'b0;
  logic        cs_in_n = 1'b0;
  logic        mem_sel_i = 1'b1;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [15:0] mem_ad_o, pld_ad_o;
  logic [2:0]  pld_ctl_o;
  logic        pld_ale_o, pld_wrh_o, mem_sel_o, pwr_down_o, turbo_on_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bus_idle_pwrdn i_bus_idle_pwrdn (
    .clk(clk), .rst_n(rst_n), .bus_ad_i(bus_ad_i), .bus_ctl_i(bus_ctl_i),
    .bus_ale_i(bus_ale_i), .bus_wrh_i(bus_wrh_i), .cs_in_n(cs_in_n),
    .mem_sel_i(mem_sel_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .mem_ad_o(mem_ad_o), .pld_ad_o(pld_ad_o),
    .pld_ctl_o(pld_ctl_o), .pld_ale_o(pld_ale_o), .pld_wrh_o(pld_wrh_o),
    .mem_sel_o(mem_sel_o), .pwr_down_o(pwr_down_o), .turbo_on_o(turbo_on_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic tog_ale();
    @(negedge clk);
    bus_ale_i = ~bus_ale_i;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_ad_i = 16'h5A3C;
    @(negedge clk);
    // R1 reset state
    chk("R1 pwr_down", pwr_down_o, 0);
    chk("R1 turbo", turbo_on_o, 1);
    chk("R1 pld_ad pass", pld_ad_o, 16'h5A3C);
    chk("R1 mem_sel pass", mem_sel_o, 1);
    repeat (300) @(negedge clk);
    chk("R1 R4 disabled after long idle", pwr_down_o, 0);
    // R1: reset idle limit 255, saturated count -> entry right after enable
    wr(2'd0, 8'h02);
    @(negedge clk);
    chk("R1 reset limit reached", pwr_down_o, 1);

    // R2 R3 sweep over idle limits
    for (int t = 0; t <= 256; t++) begin
      if (t > 10 && t < 255) continue;
      if (t == 256) break;
      wr(2'd2, t[7:0]);
      tog_ale();
      chk("R2 restart after strobe", pwr_down_o, 0);
      for (int k = 1; k <= t + 2; k++) begin
        @(negedge clk);
        chk("R3 entry timing", pwr_down_o, (k >= t + 1) ? 1 : 0);
      end
    end

    // R5 R6 R7 freeze and wake
    wr(2'd2, 8'd3);
    bus_ad_i = 16'h1111; bus_ctl_i = 3'b011; bus_wrh_i = 1'b1;
    tog_ale();
    repeat (5) @(negedge clk);
    chk("R5 powered", pwr_down_o, 1);
    bus_ad_i = 16'h2222; bus_ctl_i = 3'b100; bus_wrh_i = 1'b0;
    #1;
    chk("R5 mem_ad held", mem_ad_o, 16'h1111);
    chk("R5 pld_ad held", pld_ad_o, 16'h1111);
    chk("R5 ctl held", pld_ctl_o, 3'b011);
    chk("R5 wrh held", pld_wrh_o, 1);
    chk("R6 deselect", mem_sel_o, 0);
    @(negedge clk);
    bus_ale_i = ~bus_ale_i; bus_ad_i = 16'h3333;
    #1;
    chk("R7 held until edge", mem_ad_o, 16'h1111);
    @(negedge clk);
    chk("R7 woke", pwr_down_o, 0);
    chk("R7 mem_ad follows", mem_ad_o, 16'h3333);
    chk("R7 pld_ad follows", pld_ad_o, 16'h3333);
    chk("R7 mem_sel back", mem_sel_o, 1);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk("R7 count restarted", pwr_down_o, (k >= 4) ? 1 : 0);
    end

    // R4 clear enable while powered down
    wr(2'd0, 8'h00);
    chk("R4 one cycle later", pwr_down_o, 1);
    @(negedge clk);
    chk("R4 dropped", pwr_down_o, 0);
    repeat (50) @(negedge clk);
    chk("R4 stays off", pwr_down_o, 0);
    wr(2'd0, 8'h02);
    @(negedge clk);
    chk("R4 immediate entry", pwr_down_o, 1);
    wr(2'd0, 8'h00);
    @(negedge clk);

    // R9 low byte blocking
    bus_ad_i = 16'h1234;
    wr(2'd1, 8'h01);
    bus_ad_i = 16'hABCD;
    #1;
    chk("R9 low held upper follows", pld_ad_o, 16'hAB34);
    chk("R9 mem unaffected", mem_ad_o, 16'hABCD);

    // R10 control group blocking
    bus_ctl_i = 3'b101; bus_wrh_i = 1'b1;
    wr(2'd1, 8'h02);
    bus_ctl_i = 3'b010; bus_wrh_i = 1'b0;
    begin
      logic ale_old;
      ale_old = bus_ale_i;
      bus_ale_i = ~bus_ale_i;
      #1;
      chk("R10 ctl held", pld_ctl_o, 3'b101);
      chk("R10 wrh held", pld_wrh_o, 1);
      chk("R10 ale held", pld_ale_o, ale_old);
      chk("R9 low released", pld_ad_o, 16'hABCD);
    end
    wr(2'd2, 8'd5);
    wr(2'd0, 8'h02);
    for (int i = 0; i < 10; i++) begin
      repeat (2) @(negedge clk);
      tog_ale();
      chk("R10 monitor sees strobe", pwr_down_o, 0);
    end
    repeat (6) @(negedge clk);
    chk("R10 R3 entry after quiet", pwr_down_o, 1);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    @(negedge clk);

    // R8 chip select
    cs_in_n = 1'b1; bus_ad_i = 16'h0F0F;
    #1;
    chk("R8 deselect", mem_sel_o, 0);
    chk("R8 mem_ad follows", mem_ad_o, 16'h0F0F);
    chk("R8 pld_ad follows", pld_ad_o, 16'h0F0F);
    chk("R8 ctl follows", pld_ctl_o, 3'b010);
    cs_in_n = 1'b0;
    #1;
    chk("R8 reselect", mem_sel_o, 1);

    // R11 turbo
    wr(2'd0, 8'h01);
    chk("R11 turbo off", turbo_on_o, 0);
    wr(2'd0, 8'h00);
    chk("R11 turbo on", turbo_on_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule